// File: doc/BRIEF.md
# Trap Entry Sequencing Unit

This block performs, in a single clock edge, the architectural state change a 64-bit processor with register windows makes when it takes a trap. The pipeline presents a 9-bit trap type and a take strobe together with the current trap level, the maximum trap level, the program counter pair, condition codes, address space identifier, processor state word, window pointer, can-save count and trap base. The unit either raises the trap level or, when the level is already exhausted, enters a sticky error state.

On a taken trap the unit saves a packed state word, the program counter pair and the trap type into a per-level trap stack. It rewrites the processor state word to privileged mode with the floating-point unit enabled, and picks one of three global register sets from the trap type. It moves the window pointer for clean, spill and fill traps, and forms the new program counter from the trap base, the new level and the trap type. A read port lets the surrounding logic inspect any stack entry.

Top module: `trap_entry_unit`

## Requirements
- R1: When a strobe arrives with the trap level at or above the maximum, `err_o` rises on that edge and stays high until reset. No output other than `err_o` changes, no stack entry is written and `done_o` stays low. Later strobes are ignored while `err_o` is high.
- R2: When the trap level is below maximum minus one, `tl_o` becomes the input level plus one, and the reduced-state bit (bit 5 of the state word) comes only from the input word.
- R3: When the trap level equals maximum minus one, `tl_o` becomes the input level plus one and bit 5 of `pstate_o` is set.
- R4: The stack entry indexed by the new level (low 3 bits) receives a 40-bit state word. Condition codes are in bits 39:32, the identifier in bits 31:24, the input state word ANDed with 0xF3F in bits 19:8, and the input window pointer in bits 7:0. All other bits are zero.
- R5: The same entry stores the input PC, the input NPC and the trap type. `rd_lvl_i` selects the entry shown on the read outputs.
- R6: `pstate_o` is the input word with bit 4 (FPU enable) and bit 2 (privileged) set and exactly one global-set bit set. Type 0x060 sets bit 11. Types 0x008, 0x030 and 0x064 to 0x06F set bit 10. All other types set bit 0. The other two of bits 11, 10 and 0 are cleared, and the remaining bits pass through.
- R7: Type 0x024 (clean window) sets `cwp_o` to the window pointer minus one, modulo the window count.
- R8: Types whose value ANDed with 0x1C0 equals 0x080 (spill, 0x080 to 0x0BF) set `cwp_o` to the pointer minus can-save minus two, modulo the window count.
- R9: Types 0x0C0 to 0x0FF (fill) set `cwp_o` to the pointer plus one, modulo the window count. All other types leave the pointer unchanged.
- R10: `tbr_o` and `pc_o` equal the trap base with bits 14:0 replaced. Bit 14 is set when the new level exceeds 1, bits 13:5 hold the trap type, and bits 4:0 are zero. `npc_o` equals `pc_o` plus 4.
- R11: All outputs update on the edge that samples the strobe. `done_o` is high for exactly the one cycle after a taken trap, and the outputs hold while no strobe is present.
- R12: Reset clears every output and every stack entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| take_i | input | 1 | Take-trap strobe |
| tt_i | input | 9 | Trap type |
| tl_i | input | TL_W | Current trap level |
| maxtl_i | input | TL_W | Maximum trap level |
| pc_i | input | AW | Current PC |
| npc_i | input | AW | Current NPC |
| ccr_i | input | 8 | Condition codes |
| asi_i | input | 8 | Address space identifier |
| pstate_i | input | 12 | Current processor state word |
| cwp_i | input | CWP_W | Current window pointer |
| cansave_i | input | CWP_W | Can-save count |
| tbr_i | input | AW | Trap base |
| rd_lvl_i | input | TL_W | Stack read index |
| tl_o | output | TL_W | New trap level |
| pstate_o | output | 12 | New processor state word |
| cwp_o | output | CWP_W | New window pointer |
| pc_o | output | AW | New PC (trap vector) |
| npc_o | output | AW | New NPC |
| tbr_o | output | AW | New trap base |
| done_o | output | 1 | One-cycle taken-trap pulse |
| err_o | output | 1 | Sticky error state |
| rd_tstate_o | output | 40 | Stack entry: packed state word |
| rd_pc_o | output | AW | Stack entry: saved PC |
| rd_npc_o | output | AW | Stack entry: saved NPC |
| rd_tt_o | output | 9 | Stack entry: saved trap type |

## Verification
The assertions check the general behaviour on every cycle. They cover the level arithmetic and the error latch, the reduced-state bit at the last level, the privileged and FPU bits with exactly one global set selected, the NPC-to-PC spacing with its aligned vector, and the one-cycle done pulse with outputs held between traps. The per-type details need the bench's scenarios. These are the choice of global set, the modular window arithmetic for clean, spill and fill traps, the exact packing of the stack word, the vector bits and the entry written at each level.

// File: rtl/trap_pkg.sv
package trap_pkg;
    localparam int TT_W = 9;
    localparam int PS_W = 12;
    localparam int TS_W = 40;

    localparam int PS_AG  = 0;
    localparam int PS_PRV = 2;
    localparam int PS_FPE = 4;
    localparam int PS_RED = 5;
    localparam int PS_MG  = 10;
    localparam int PS_IG  = 11;

    localparam logic [TT_W-1:0] TT_INST_FAULT = 9'h008;
    localparam logic [TT_W-1:0] TT_CLEAN      = 9'h024;
    localparam logic [TT_W-1:0] TT_DATA_FAULT = 9'h030;
    localparam logic [TT_W-1:0] TT_INT_VEC    = 9'h060;
    localparam logic [TT_W-1:0] TT_IMISS      = 9'h064;
    localparam logic [TT_W-1:0] TT_DMISS      = 9'h068;
    localparam logic [TT_W-1:0] TT_DPROT      = 9'h06C;
    localparam logic [TT_W-1:0] TT_WIN_MASK   = 9'h1C0;
    localparam logic [TT_W-1:0] TT_SPILL      = 9'h080;
    localparam logic [TT_W-1:0] TT_FILL       = 9'h0C0;

    localparam logic [PS_W-1:0] PS_SAVE_MASK  = 12'hF3F;

    typedef enum logic [1:0] {
        GSET_ALT = 2'd0,
        GSET_MMU = 2'd1,
        GSET_INT = 2'd2
    } gset_e;

    function automatic gset_e pick_gset(input logic [TT_W-1:0] tt);
        logic [TT_W-1:0] base4;
        base4 = {tt[TT_W-1:2], 2'b00};
        if (tt == TT_INT_VEC)
            return GSET_INT;
        else if (tt == TT_INST_FAULT || tt == TT_DATA_FAULT ||
                 base4 == TT_IMISS || base4 == TT_DMISS || base4 == TT_DPROT)
            return GSET_MMU;
        else
            return GSET_ALT;
    endfunction
endpackage

// File: rtl/trap_level_calc.sv
module trap_level_calc #(
    parameter int TL_W = 3
) (
    input  logic [TL_W-1:0] tl_i,
    input  logic [TL_W-1:0] maxtl_i,
    output logic            fault_o,
    output logic            last_o,
    output logic [TL_W-1:0] tl_next_o
);
    logic [TL_W:0] tl_plus;

    always_comb begin
        tl_plus   = {1'b0, tl_i} + 1'b1;
        fault_o   = (tl_i >= maxtl_i);
        last_o    = (tl_plus == {1'b0, maxtl_i});
        tl_next_o = tl_i + 1'b1;
    end
endmodule

// File: rtl/trap_window_calc.sv
module trap_window_calc
    import trap_pkg::*;
#(
    parameter int NWIN  = 8,
    parameter int CWP_W = 3
) (
    input  logic [TT_W-1:0]  tt_i,
    input  logic [CWP_W-1:0] cwp_i,
    input  logic [CWP_W-1:0] cansave_i,
    output logic [CWP_W-1:0] cwp_o
);
    localparam int EW = CWP_W + 3;
    localparam logic [EW-1:0] NW_E = EW'(NWIN);
    localparam logic [CWP_W-1:0] TOP = CWP_W'(NWIN - 1);

    logic [EW-1:0] spill_raw;
    logic [EW-1:0] spill_red;

    always_comb begin
        spill_raw = EW'(cwp_i) + EW'(2 * NWIN) - EW'(cansave_i) - EW'(2);
        spill_red = spill_raw;
        for (int k = 0; k < 2; k++) begin
            if (spill_red >= NW_E)
                spill_red = spill_red - NW_E;
        end

        if (tt_i == TT_CLEAN)
            cwp_o = (cwp_i == '0) ? TOP : cwp_i - 1'b1;
        else if ((tt_i & TT_WIN_MASK) == TT_SPILL)
            cwp_o = CWP_W'(spill_red);
        else if ((tt_i & TT_WIN_MASK) == TT_FILL)
            cwp_o = (cwp_i == TOP) ? '0 : cwp_i + 1'b1;
        else
            cwp_o = cwp_i;
    end
endmodule

// File: rtl/trap_vector_calc.sv
module trap_vector_calc
    import trap_pkg::*;
#(
    parameter int AW   = 64,
    parameter int TL_W = 3
) (
    input  logic [AW-1:0]   tbr_i,
    input  logic [TL_W-1:0] tl_next_i,
    input  logic [TT_W-1:0] tt_i,
    output logic [AW-1:0]   vec_o
);
    localparam logic [AW-1:0] LOW_MASK = AW'(15'h7FFF);

    always_comb begin
        vec_o = (tbr_i & ~LOW_MASK)
              | (AW'(tl_next_i > TL_W'(1)) << 14)
              | (AW'(tt_i) << 5);
    end
endmodule

// File: rtl/trap_stack.sv
module trap_stack
    import trap_pkg::*;
#(
    parameter int AW   = 64,
    parameter int TL_W = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            we_i,
    input  logic [TL_W-1:0] wr_idx_i,
    input  logic [TS_W-1:0] wr_tstate_i,
    input  logic [AW-1:0]   wr_pc_i,
    input  logic [AW-1:0]   wr_npc_i,
    input  logic [TT_W-1:0] wr_tt_i,
    input  logic [TL_W-1:0] rd_idx_i,
    output logic [TS_W-1:0] rd_tstate_o,
    output logic [AW-1:0]   rd_pc_o,
    output logic [AW-1:0]   rd_npc_o,
    output logic [TT_W-1:0] rd_tt_o
);
    localparam int DEPTH = 2 ** TL_W;
    localparam int EW    = TS_W + 2 * AW + TT_W;

    logic [EW-1:0] ent_q [DEPTH];
    logic [EW-1:0] wr_word;

    assign wr_word = {wr_tstate_i, wr_pc_i, wr_npc_i, wr_tt_i};

    for (genvar g = 0; g < DEPTH; g++) begin : g_ent
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                ent_q[g] <= '0;
            else if (we_i && wr_idx_i == TL_W'(g))
                ent_q[g] <= wr_word;
        end
    end

    assign {rd_tstate_o, rd_pc_o, rd_npc_o, rd_tt_o} = ent_q[rd_idx_i];
endmodule

// File: rtl/trap_entry_unit.sv
module trap_entry_unit
    import trap_pkg::*;
#(
    parameter int AW   = 64,
    parameter int TL_W = 3,
    parameter int NWIN = 8,
    localparam int CWP_W = (NWIN > 1) ? $clog2(NWIN) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             take_i,
    input  logic [TT_W-1:0]  tt_i,
    input  logic [TL_W-1:0]  tl_i,
    input  logic [TL_W-1:0]  maxtl_i,
    input  logic [AW-1:0]    pc_i,
    input  logic [AW-1:0]    npc_i,
    input  logic [7:0]       ccr_i,
    input  logic [7:0]       asi_i,
    input  logic [PS_W-1:0]  pstate_i,
    input  logic [CWP_W-1:0] cwp_i,
    input  logic [CWP_W-1:0] cansave_i,
    input  logic [AW-1:0]    tbr_i,
    input  logic [TL_W-1:0]  rd_lvl_i,
    output logic [TL_W-1:0]  tl_o,
    output logic [PS_W-1:0]  pstate_o,
    output logic [CWP_W-1:0] cwp_o,
    output logic [AW-1:0]    pc_o,
    output logic [AW-1:0]    npc_o,
    output logic [AW-1:0]    tbr_o,
    output logic             done_o,
    output logic             err_o,
    output logic [TS_W-1:0]  rd_tstate_o,
    output logic [AW-1:0]    rd_pc_o,
    output logic [AW-1:0]    rd_npc_o,
    output logic [TT_W-1:0]  rd_tt_o
);
    typedef struct packed {
        logic [TL_W-1:0]  tl;
        logic [PS_W-1:0]  pstate;
        logic [CWP_W-1:0] cwp;
        logic [AW-1:0]    pc;
        logic [AW-1:0]    npc;
        logic [AW-1:0]    tbr;
        logic             done;
        logic             err;
    } arch_t;

    arch_t st_d, st_q;

    logic            lvl_fault, lvl_last;
    logic [TL_W-1:0] tl_next;
    logic [CWP_W-1:0] cwp_next;
    logic [AW-1:0]   vec;
    logic [PS_W-1:0] ps_next;
    logic [TS_W-1:0] tstate_w;
    logic            stk_we;
    gset_e           gset;

    trap_level_calc #(.TL_W(TL_W)) u_level (
        .tl_i      (tl_i),
        .maxtl_i   (maxtl_i),
        .fault_o   (lvl_fault),
        .last_o    (lvl_last),
        .tl_next_o (tl_next)
    );

    trap_window_calc #(.NWIN(NWIN), .CWP_W(CWP_W)) u_window (
        .tt_i      (tt_i),
        .cwp_i     (cwp_i),
        .cansave_i (cansave_i),
        .cwp_o     (cwp_next)
    );

    trap_vector_calc #(.AW(AW), .TL_W(TL_W)) u_vector (
        .tbr_i     (tbr_i),
        .tl_next_i (tl_next),
        .tt_i      (tt_i),
        .vec_o     (vec)
    );

    always_comb begin
        gset    = pick_gset(tt_i);
        ps_next = pstate_i;
        ps_next[PS_AG]  = (gset == GSET_ALT);
        ps_next[PS_MG]  = (gset == GSET_MMU);
        ps_next[PS_IG]  = (gset == GSET_INT);
        ps_next[PS_FPE] = 1'b1;
        ps_next[PS_PRV] = 1'b1;
        if (lvl_last)
            ps_next[PS_RED] = 1'b1;

        tstate_w = {ccr_i, asi_i, 4'b0000, pstate_i & PS_SAVE_MASK, 8'(cwp_i)};

        st_d      = st_q;
        st_d.done = 1'b0;
        stk_we    = 1'b0;
        if (take_i && !st_q.err) begin
            if (lvl_fault) begin
                st_d.err = 1'b1;
            end else begin
                st_d.tl     = tl_next;
                st_d.pstate = ps_next;
                st_d.cwp    = cwp_next;
                st_d.tbr    = vec;
                st_d.pc     = vec;
                st_d.npc    = vec + AW'(4);
                st_d.done   = 1'b1;
                stk_we      = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    trap_stack #(.AW(AW), .TL_W(TL_W)) u_stack (
        .clk         (clk),
        .rst_n       (rst_n),
        .we_i        (stk_we),
        .wr_idx_i    (tl_next),
        .wr_tstate_i (tstate_w),
        .wr_pc_i     (pc_i),
        .wr_npc_i    (npc_i),
        .wr_tt_i     (tt_i),
        .rd_idx_i    (rd_lvl_i),
        .rd_tstate_o (rd_tstate_o),
        .rd_pc_o     (rd_pc_o),
        .rd_npc_o    (rd_npc_o),
        .rd_tt_o     (rd_tt_o)
    );

    assign tl_o     = st_q.tl;
    assign pstate_o = st_q.pstate;
    assign cwp_o    = st_q.cwp;
    assign pc_o     = st_q.pc;
    assign npc_o    = st_q.npc;
    assign tbr_o    = st_q.tbr;
    assign done_o   = st_q.done;
    assign err_o    = st_q.err;
endmodule

// File: rtl/trap_entry_chk.sv
module trap_entry_chk
    import trap_pkg::*;
#(
    parameter int AW   = 64,
    parameter int TL_W = 3
) (
    input logic            clk,
    input logic            rst_n,
    input logic            take_i,
    input logic [TL_W-1:0] tl_i,
    input logic [TL_W-1:0] maxtl_i,
    input logic [TL_W-1:0] tl_o,
    input logic [PS_W-1:0] pstate_o,
    input logic [AW-1:0]   pc_o,
    input logic [AW-1:0]   npc_o,
    input logic            done_o,
    input logic            err_o
);
    logic go;
    assign go = take_i && !err_o && (tl_i < maxtl_i);

    p_fault_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (take_i && !err_o && tl_i >= maxtl_i) |=> (err_o && !done_o && tl_o == $past(tl_o)));

    p_err_sticky_r1: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |=> err_o);

    p_tl_inc_r2: assert property (@(posedge clk) disable iff (!rst_n)
        go |=> (tl_o == $past(tl_i) + 1'b1));

    p_red_last_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (go && TL_W'(tl_i + 1'b1) == maxtl_i) |=> pstate_o[PS_RED]);

    p_mode_bits_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (pstate_o[PS_FPE] && pstate_o[PS_PRV] &&
                    $countones({pstate_o[PS_IG], pstate_o[PS_MG], pstate_o[PS_AG]}) == 1));

    p_npc_step_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (npc_o == pc_o + AW'(4) && pc_o[4:0] == 5'd0));

    p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
        go |=> done_o);

    p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !take_i |=> (!done_o && $stable(tl_o) && $stable(pc_o) && $stable(pstate_o)));
endmodule

bind trap_entry_unit trap_entry_chk #(.AW(AW), .TL_W(TL_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .take_i   (take_i),
    .tl_i     (tl_i),
    .maxtl_i  (maxtl_i),
    .tl_o     (tl_o),
    .pstate_o (pstate_o),
    .pc_o     (pc_o),
    .npc_o    (npc_o),
    .done_o   (done_o),
    .err_o    (err_o)
);

// File: tb/tb_trap_entry_unit.sv
module tb_trap_entry_unit;
    localparam int PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        take_i = 1'b0;
    logic [8:0]  tt_i = '0;
    logic [2:0]  tl_i = '0, maxtl_i = '0;
    logic [63:0] pc_i = '0, npc_i = '0, tbr_i = '0;
    logic [7:0]  ccr_i = '0, asi_i = '0;
    logic [11:0] pstate_i = '0;
    logic [2:0]  cwp_i = '0, cansave_i = '0;
    logic [2:0]  rd_lvl_i = '0;
    logic [2:0]  tl_o, cwp_o;
    logic [11:0] pstate_o;
    logic [63:0] pc_o, npc_o, tbr_o, rd_pc_o, rd_npc_o;
    logic        done_o, err_o;
    logic [39:0] rd_tstate_o;
    logic [8:0]  rd_tt_o;

    trap_entry_unit dut (.*);

    always #(PERIOD/2) clk = ~clk;

    int n_chk = 0;
    int n_err = 0;

    typedef struct {
        logic        done, err;
        logic [2:0]  tl, cwp, idx;
        logic [11:0] ps;
        logic [63:0] pc, npc, tbr, spc, snpc;
        logic [39:0] sts;
        logic [8:0]  stt;
        string       req;
    } exp_t;

    exp_t q[$];

    logic [2:0]  m_tl, m_cwp;
    logic [11:0] m_ps;
    logic [63:0] m_pc, m_npc, m_tbr;
    logic        m_err;
    logic [39:0] m_sts [8];
    logic [63:0] m_spc [8], m_snpc [8];
    logic [8:0]  m_stt [8];

    task automatic chk(input logic ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic model_reset();
        m_tl = 0; m_cwp = 0; m_ps = 0; m_pc = 0; m_npc = 0; m_tbr = 0; m_err = 0;
        for (int i = 0; i < 8; i++) begin
            m_sts[i] = 0; m_spc[i] = 0; m_snpc[i] = 0; m_stt[i] = 0;
        end
    endtask

    task automatic do_trap(input logic [8:0] tt, input logic [2:0] tl, input logic [2:0] mx,
                           input logic [11:0] ps, input logic [2:0] cwp, input logic [2:0] cs,
                           input string req);
        exp_t e;
        logic [2:0]  ntl, idx;
        logic [11:0] nps;
        logic [63:0] vec, pcv, npcv, tbv;
        pcv  = 64'h0000_1234_0000_0100 + {55'd0, tt};
        npcv = pcv + 64'd4;
        tbv  = 64'hFFFF_0000_ABCD_7FFF ^ {61'd0, tl};
        @(negedge clk);
        take_i = 1'b1; tt_i = tt; tl_i = tl; maxtl_i = mx; pstate_i = ps;
        cwp_i = cwp; cansave_i = cs; pc_i = pcv; npc_i = npcv; tbr_i = tbv;
        ccr_i = 8'hC3 ^ tt[7:0]; asi_i = 8'h80 | {5'd0, tl};
        ntl = tl + 3'd1;
        idx = ntl;
        if (m_err || tl >= mx) begin
            m_err = 1'b1;
            e.done = 1'b0;
        end else begin
            nps = ps & ~12'h801 & ~12'h400;
            nps = nps | 12'h014;
            if (tt == 9'h060) nps = nps | 12'h800;
            else if (tt == 9'h008 || tt == 9'h030 || (tt >= 9'h064 && tt <= 9'h06F)) nps = nps | 12'h400;
            else nps = nps | 12'h001;
            if (tl == mx - 3'd1) nps = nps | 12'h020;
            m_ps = nps;
            if (tt == 9'h024) m_cwp = (cwp + 3'd7) % 8;
            else if (tt >= 9'h080 && tt <= 9'h0BF) m_cwp = 3'((int'(cwp) + 16 - int'(cs) - 2) % 8);
            else if (tt >= 9'h0C0 && tt <= 9'h0FF) m_cwp = (cwp + 3'd1) % 8;
            else m_cwp = cwp;
            vec = {tbv[63:15], (ntl > 3'd1), tt, 5'd0};
            m_tl = ntl; m_pc = vec; m_npc = vec + 64'd4; m_tbr = vec;
            m_sts[idx]  = {ccr_i, asi_i, 4'd0, ps & 12'hF3F, 5'd0, cwp};
            m_spc[idx]  = pcv; m_snpc[idx] = npcv; m_stt[idx] = tt;
            e.done = 1'b1;
        end
        e.err = m_err; e.tl = m_tl; e.cwp = m_cwp; e.ps = m_ps; e.pc = m_pc;
        e.npc = m_npc; e.tbr = m_tbr; e.idx = idx; e.sts = m_sts[idx];
        e.spc = m_spc[idx]; e.snpc = m_snpc[idx]; e.stt = m_stt[idx]; e.req = req;
        q.push_back(e);
        @(negedge clk);
        take_i = 1'b0;
    endtask

    initial begin : monitor
        exp_t e;
        forever begin
            @(posedge clk);
            #2;
            if (q.size() > 0) begin
                e = q.pop_front();
                chk(done_o == e.done, {e.req, " R11 done"}, 64'(done_o), 64'(e.done));
                chk(err_o == e.err, {e.req, " R1 err"}, 64'(err_o), 64'(e.err));
                chk(tl_o == e.tl, {e.req, " R2 level"}, 64'(tl_o), 64'(e.tl));
                chk(pstate_o == e.ps, {e.req, " R6 pstate"}, 64'(pstate_o), 64'(e.ps));
                chk(cwp_o == e.cwp, {e.req, " R9 cwp"}, 64'(cwp_o), 64'(e.cwp));
                chk(pc_o == e.pc, {e.req, " R10 pc"}, pc_o, e.pc);
                chk(npc_o == e.npc, {e.req, " R10 npc"}, npc_o, e.npc);
                chk(tbr_o == e.tbr, {e.req, " R10 tbr"}, tbr_o, e.tbr);
                rd_lvl_i = e.idx;
                #1;
                chk(rd_tstate_o == e.sts, {e.req, " R4 tstate"}, 64'(rd_tstate_o), 64'(e.sts));
                chk(rd_pc_o == e.spc, {e.req, " R5 saved pc"}, rd_pc_o, e.spc);
                chk(rd_npc_o == e.snpc, {e.req, " R5 saved npc"}, rd_npc_o, e.snpc);
                chk(rd_tt_o == e.stt, {e.req, " R5 saved tt"}, 64'(rd_tt_o), 64'(e.stt));
            end
        end
    end

    task automatic idle_check(input string req);
        @(posedge clk);
        #2;
        chk(done_o == 1'b0, {req, " R11 done drops"}, 64'(done_o), 64'd0);
        chk(tl_o == m_tl && pc_o == m_pc && cwp_o == m_cwp, {req, " R11 hold"}, pc_o, m_pc);
    endtask

    task automatic reset_check(input string req);
        chk(tl_o == 0 && cwp_o == 0 && pstate_o == 0, {req, " R12 state"}, 64'(pstate_o), 64'd0);
        chk(pc_o == 0 && npc_o == 0 && tbr_o == 0, {req, " R12 vector"}, pc_o, 64'd0);
        chk(done_o == 0 && err_o == 0, {req, " R12 flags"}, 64'({done_o, err_o}), 64'd0);
    endtask

    initial begin : watchdog
        #(PERIOD * 20000);
        n_chk++; n_err++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin : main
        model_reset();
        repeat (3) @(negedge clk);
        reset_check("reset");
        rst_n = 1'b1;
        do_trap(9'h024, 3'd0, 3'd5, 12'h0C1, 3'd0, 3'd0, "R7 clean wrap");
        idle_check("after clean");
        do_trap(9'h060, 3'd1, 3'd5, 12'h402, 3'd3, 3'd1, "R6 int vector");
        do_trap(9'h066, 3'd2, 3'd5, 12'h801, 3'd4, 3'd2, "R6 mmu miss");
        do_trap(9'h008, 3'd0, 3'd5, 12'h0, 3'd2, 3'd2, "R6 inst fault");
        do_trap(9'h030, 3'd1, 3'd5, 12'hFFF, 3'd5, 3'd0, "R6 data fault");
        do_trap(9'h06F, 3'd2, 3'd5, 12'h100, 3'd6, 3'd0, "R6 dprot top");
        do_trap(9'h070, 3'd2, 3'd5, 12'h400, 3'd6, 3'd0, "R6 alt after dprot");
        do_trap(9'h084, 3'd1, 3'd5, 12'h010, 3'd1, 3'd5, "R8 spill wrap");
        do_trap(9'h0BF, 3'd0, 3'd5, 12'h010, 3'd7, 3'd0, "R8 spill top");
        do_trap(9'h0C4, 3'd2, 3'd5, 12'h0, 3'd7, 3'd0, "R9 fill wrap");
        do_trap(9'h110, 3'd3, 3'd5, 12'h0, 3'd5, 3'd3, "R9 trap insn keeps cwp");
        idle_check("after burst");
        do_trap(9'h041, 3'd3, 3'd5, 12'h000, 3'd2, 3'd1, "R2 below last");
        do_trap(9'h041, 3'd4, 3'd5, 12'h000, 3'd2, 3'd1, "R3 last level");
        do_trap(9'h022, 3'd0, 3'd1, 12'h000, 3'd2, 3'd1, "R3 max one");
        do_trap(9'h042, 3'd6, 3'd7, 12'h000, 3'd2, 3'd1, "R4 top entry");
        do_trap(9'h043, 3'd5, 3'd5, 12'h000, 3'd2, 3'd1, "R1 at max");
        idle_check("after error");
        do_trap(9'h044, 3'd0, 3'd5, 12'h000, 3'd2, 3'd1, "R1 ignored in error");
        @(negedge clk);
        rst_n = 1'b0;
        model_reset();
        @(negedge clk);
        reset_check("mid reset");
        rst_n = 1'b1;
        do_trap(9'h045, 3'd0, 3'd0, 12'h000, 3'd2, 3'd1, "R1 max zero");
        do_trap(9'h10A, 3'd0, 3'd5, 12'h000, 3'd2, 3'd1, "R1 sticky");
        repeat (3) @(negedge clk);
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule